// File: doc/BRIEF.md
# Array-Sum Loop Engine with Patch Scan Path

This block is a fixed-function engine for a single hot loop. Given a base byte address and a count `n`, it walks the index from zero while the index stays below `n`. At each step it reads one signed 32-bit word at `base + 4*index` and folds the word into an accumulator. When the loop ends it hands the accumulator back to the host. The controller has one state per basic block of the loop: entry, loop test, body, index step and exit. The datapath has its own distributed registers and no register file. All reads go through one read port, the same one the host uses, so the engine sees the host's view of memory.

Later software changes can be absorbed in three ways. The index step and the starting accumulator value are host-writable constants. The accumulate operation can be switched between add and subtract. A patch mask can also stop the controller on entry to any chosen basic block. When it stops, the live state (block, index, accumulator, count, base, step, operator) is copied into a shadow scan chain. The host shifts that chain out, runs replacement code, shifts the edited state back in and pulses resume. Execution then continues in the block that was scanned in.

Top module: `sumloop_accel`

## Requirements
- R1: When idle with an empty patch mask, a one-cycle `start_i` captures `base_i` and `count_i`. The block then raises `done_o` for exactly one cycle with `result_o` = init ⊕ w(0) ⊕ w(s) ⊕ w(2s) ⊕ ..., where w(i) is the word at `base + 4*i`, the index runs while it is less than the count, s is the step constant, and ⊕ is the configured operation.
- R2: With a count of zero, `done_o` fires with `result_o` equal to the initial accumulator value and no read request is made.
- R3: The read port uses valid/ready with one read outstanding. A request with ready low holds valid and address steady. Each request address is `base + 4*index` with 32-bit wrap-around. After a handshake, the engine waits for `mem_rsp_valid_i` before going on.
- R4: The index advances by the step constant. The step is written with `cfg_sel_i`=0 (low 16 bits of `cfg_data_i`) and resets to 1.
- R5: The initial accumulator value is written with `cfg_sel_i`=1 and resets to 0.
- R6: The operator bit is written with `cfg_sel_i`=2 from bit 0 (1 = subtract the word from the accumulator, 0 = add) and resets to 0.
- R7: The patch mask is written with `cfg_sel_i`=3 from the low 8 bits, and resets to 0. Bit k stops the engine on entry to the block with code k: entry=1, test=2, body=3, step=4, exit=5 (idle=0 and bits 0, 6 and 7 have no effect). While stopped, `exc_o` stays high and the engine issues no request and no `done_o` until resume.
- R8: The scan chain is 116 bits long. From the `scan_out_o` end it holds block code (3), index (16), accumulator (32), count (16), base (32), step (16) and operator (1), each field MSB first. On a stop it is loaded with the state of the block being entered. On completion it is loaded with the final state, with the block code set to idle. `scan_out_o` shows the head bit, and each shift cycle moves in `scan_in_i` at the tail.
- R9: Shifting happens only while stopped or idle. It never changes the live state. Shifting while idle has no effect on a following job.
- R10: A resume pulse while stopped loads the whole chain into the live state and clears `exc_o`. Execution continues at the scanned-in block, and the mask is not checked again for that block.
- R11: `start_i` is ignored unless the engine is idle and not stopped. Configuration writes are likewise ignored unless the engine is idle.
- R12: After reset, `done_o`, `mem_req_valid_o`, `exc_o` and `scan_out_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Job start pulse |
| base_i | input | 32 | Base byte address of the array |
| count_i | input | 16 | Element count |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Accumulator, valid with done_o |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Configuration register select |
| cfg_data_i | input | 32 | Configuration write data |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Read request accepted |
| mem_req_addr_o | output | 32 | Read byte address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Read data |
| exc_o | output | 1 | Stopped at a patched block |
| scan_en_i | input | 1 | Shift the scan chain one bit |
| scan_in_i | input | 1 | Serial data into the chain tail |
| scan_out_o | output | 1 | Chain head bit |
| resume_i | input | 1 | Load chain into live state and continue |

## Verification
A wrong index or step shows at the read port: the very next request address differs from `base + 4*index`. A wrong accumulator or operator stays hidden until the final `done_o`, or until the next stop shifts it out over the scan chain. A wrong block code or a missed mask check shows within one cycle as an unexpected request, a missing `exc_o`, or a `done_o` that comes too early or too late. A faulty capture or resume load is caught by comparing the shifted-out vector against the expected state, and by the final sum after an edited resume.

// File: rtl/sumloop_pkg.sv
`timescale 1ns/100ps
package sumloop_pkg;
  localparam int ST_W   = 3;
  localparam int MASK_W = 1 << ST_W;

  // basic-block codes; values are visible on the scan chain
  typedef enum logic [ST_W-1:0] {
    ST_IDLE = 3'd0,
    ST_INIT = 3'd1,
    ST_TEST = 3'd2,
    ST_BODY = 3'd3,
    ST_STEP = 3'd4,
    ST_EXIT = 3'd5
  } blk_e;

  localparam logic [1:0] CFG_STEP = 2'd0;
  localparam logic [1:0] CFG_INIT = 2'd1;
  localparam logic [1:0] CFG_OP   = 2'd2;
  localparam logic [1:0] CFG_MASK = 2'd3;
endpackage

// File: rtl/sumloop_ctrl.sv
`timescale 1ns/100ps
module sumloop_ctrl
  import sumloop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              lt_i,
  input  logic              req_ready_i,
  input  logic              rsp_valid_i,
  input  logic              resume_i,
  input  logic [ST_W-1:0]   resume_st_i,
  output blk_e              st_q,
  output blk_e              st_d,
  output logic              paused_q,
  output logic              do_start_o,
  output logic              do_init_o,
  output logic              do_acc_o,
  output logic              do_step_o,
  output logic              req_valid_o,
  output logic              done_o,
  output logic              pause_ev_o,
  output logic              resume_fire_o
);
  logic run;
  logic sent_q;
  blk_e nxt;

  assign run = !paused_q;

  // block-to-block transfer, taken from the loop's control flow
  always_comb begin
    nxt = st_q;
    if (run) begin
      case (st_q)
        ST_IDLE: if (start_i) nxt = ST_INIT;
        ST_INIT: nxt = ST_TEST;
        ST_TEST: nxt = lt_i ? ST_BODY : ST_EXIT;
        ST_BODY: if (sent_q && rsp_valid_i) nxt = ST_STEP;
        ST_STEP: nxt = ST_TEST;
        ST_EXIT: nxt = ST_IDLE;
        default: nxt = ST_IDLE;
      endcase
    end
  end

  assign pause_ev_o    = run && (nxt != st_q) && (nxt != ST_IDLE) && mask_i[nxt];
  assign resume_fire_o = paused_q && resume_i;
  assign st_d          = resume_fire_o ? blk_e'(resume_st_i) : nxt;

  assign do_start_o  = run && (st_q == ST_IDLE) && start_i;
  assign do_init_o   = run && (st_q == ST_INIT);
  assign do_acc_o    = run && (st_q == ST_BODY) && sent_q && rsp_valid_i;
  assign do_step_o   = run && (st_q == ST_STEP);
  assign req_valid_o = run && (st_q == ST_BODY) && !sent_q;
  assign done_o      = run && (st_q == ST_EXIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      paused_q <= 1'b0;
      sent_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (resume_fire_o)   paused_q <= 1'b0;
      else if (pause_ev_o) paused_q <= 1'b1;
      if (req_valid_o && req_ready_i) sent_q <= 1'b1;
      else if (do_acc_o)              sent_q <= 1'b0;
    end
  end

  // R7: a stopped engine stays where it is until the host resumes it
  p_pause_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    paused_q && !resume_i |=> paused_q && $stable(st_q))
    else $error("p_pause_holds_r7");

  // R10: resume continues in the block taken from the chain
  p_resume_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resume_fire_o |=> (st_q == $past(resume_st_i)) && !paused_q)
    else $error("p_resume_state_r10");
endmodule

// File: rtl/sumloop_datapath.sv
`timescale 1ns/100ps
module sumloop_datapath
  import sumloop_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int IW = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_i,
  input  logic              do_start_i,
  input  logic              do_init_i,
  input  logic              do_acc_i,
  input  logic              do_step_i,
  input  logic              ld_i,
  input  logic              cfg_wr_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [DW-1:0]     cfg_data_i,
  input  logic [AW-1:0]     base_i,
  input  logic [IW-1:0]     count_i,
  input  logic [DW-1:0]     rsp_data_i,
  input  logic [IW-1:0]     sh_idx_i,
  input  logic [DW-1:0]     sh_acc_i,
  input  logic [IW-1:0]     sh_n_i,
  input  logic [AW-1:0]     sh_base_i,
  input  logic [IW-1:0]     sh_inc_i,
  input  logic              sh_sub_i,
  output logic [IW-1:0]     idx_q,
  output logic [DW-1:0]     acc_q,
  output logic [IW-1:0]     idx_d,
  output logic [DW-1:0]     acc_d,
  output logic [IW-1:0]     n_d,
  output logic [AW-1:0]     base_d,
  output logic [IW-1:0]     inc_d,
  output logic              sub_d,
  output logic [MASK_W-1:0] mask_q,
  output logic              lt_o,
  output logic [AW-1:0]     addr_o
);
  logic [IW-1:0] n_q;
  logic [AW-1:0] base_q;
  logic [IW-1:0] inc_q;
  logic          sub_q;
  logic [DW-1:0] init_q;

  function automatic logic [DW-1:0] alu_f(input logic [DW-1:0] a,
                                          input logic [DW-1:0] b,
                                          input logic          sub);
    return sub ? (a - b) : (a + b);
  endfunction

  function automatic logic [AW-1:0] addr_f(input logic [AW-1:0] base,
                                           input logic [IW-1:0] idx);
    return base + (AW'(idx) << 2);
  endfunction

  assign lt_o   = idx_q < n_q;
  assign addr_o = addr_f(base_q, idx_q);

  always_comb begin
    idx_d  = idx_q;
    acc_d  = acc_q;
    n_d    = n_q;
    base_d = base_q;
    inc_d  = inc_q;
    sub_d  = sub_q;
    if (ld_i) begin
      idx_d  = sh_idx_i;
      acc_d  = sh_acc_i;
      n_d    = sh_n_i;
      base_d = sh_base_i;
      inc_d  = sh_inc_i;
      sub_d  = sh_sub_i;
    end else begin
      if (do_start_i) begin
        n_d    = count_i;
        base_d = base_i;
      end
      if (do_init_i) begin
        idx_d = '0;
        acc_d = init_q;
      end
      if (do_acc_i)  acc_d = alu_f(acc_q, rsp_data_i, sub_q);
      if (do_step_i) idx_d = idx_q + inc_q;
      if (cfg_wr_i && cfg_sel_i == CFG_STEP) inc_d = cfg_data_i[IW-1:0];
      if (cfg_wr_i && cfg_sel_i == CFG_OP)   sub_d = cfg_data_i[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      acc_q  <= '0;
      n_q    <= '0;
      base_q <= '0;
      inc_q  <= IW'(1);
      sub_q  <= 1'b0;
      init_q <= '0;
      mask_q <= '0;
    end else begin
      idx_q  <= idx_d;
      acc_q  <= acc_d;
      n_q    <= n_d;
      base_q <= base_d;
      inc_q  <= inc_d;
      sub_q  <= sub_d;
      if (cfg_wr_i && cfg_sel_i == CFG_INIT) init_q <= cfg_data_i;
      if (cfg_wr_i && cfg_sel_i == CFG_MASK) mask_q <= cfg_data_i[MASK_W-1:0];
    end
  end

  // R9: while stopped, nothing but a resume touches the live loop registers
  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i && !ld_i |=> $stable(idx_q) && $stable(acc_q))
    else $error("p_hold_stable_r9");
endmodule

// File: rtl/sumloop_scan.sv
`timescale 1ns/100ps
module sumloop_scan #(
  parameter int LEN = 116
)(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cap_i,
  input  logic [LEN-1:0] cap_vec_i,
  input  logic           shift_i,
  input  logic           sin_i,
  output logic [LEN-1:0] chain_q,
  output logic           sout_o
);
  assign sout_o = chain_q[LEN-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       chain_q <= '0;
    else if (cap_i)   chain_q <= cap_vec_i;
    else if (shift_i) chain_q <= {chain_q[LEN-2:0], sin_i};
  end

  // R8: a capture leaves exactly the presented live state in the chain
  p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> chain_q == $past(cap_vec_i))
    else $error("p_capture_r8");
endmodule

// File: rtl/sumloop_accel.sv
`timescale 1ns/100ps
module sumloop_accel
  import sumloop_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int IW = 16
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] base_i,
  input  logic [IW-1:0] count_i,
  output logic          done_o,
  output logic [DW-1:0] result_o,
  input  logic          cfg_wr_i,
  input  logic [1:0]    cfg_sel_i,
  input  logic [DW-1:0] cfg_data_i,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic [AW-1:0] mem_req_addr_o,
  input  logic          mem_rsp_valid_i,
  input  logic [DW-1:0] mem_rsp_data_i,
  output logic          exc_o,
  input  logic          scan_en_i,
  input  logic          scan_in_i,
  output logic          scan_out_o,
  input  logic          resume_i
);
  localparam int LEN = ST_W + IW + DW + IW + AW + IW + 1;

  blk_e              st_q, st_d;
  logic              paused_q;
  logic              do_start, do_init, do_acc, do_step;
  logic              pause_ev, resume_fire;
  logic              lt;
  logic [MASK_W-1:0] mask_q;
  logic [IW-1:0]     idx_q, idx_d, n_d, inc_d;
  logic [DW-1:0]     acc_q, acc_d;
  logic [AW-1:0]     base_d;
  logic              sub_d;
  logic [LEN-1:0]    chain_q, cap_vec;
  logic [ST_W-1:0]   sh_st;
  logic [IW-1:0]     sh_idx, sh_n, sh_inc;
  logic [DW-1:0]     sh_acc;
  logic [AW-1:0]     sh_base;
  logic              sh_sub;
  logic              host_idle, cap, shift;

  assign host_idle = (st_q == ST_IDLE) && !paused_q;
  assign cap       = pause_ev || done_o;
  assign shift     = scan_en_i && (paused_q || st_q == ST_IDLE) && !resume_fire && !cap;
  assign cap_vec   = {st_d, idx_d, acc_d, n_d, base_d, inc_d, sub_d};
  assign {sh_st, sh_idx, sh_acc, sh_n, sh_base, sh_inc, sh_sub} = chain_q;
  assign exc_o     = paused_q;
  assign result_o  = acc_q;

  sumloop_ctrl i_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .mask_i        (mask_q),
    .lt_i          (lt),
    .req_ready_i   (mem_req_ready_i),
    .rsp_valid_i   (mem_rsp_valid_i),
    .resume_i      (resume_i),
    .resume_st_i   (sh_st),
    .st_q          (st_q),
    .st_d          (st_d),
    .paused_q      (paused_q),
    .do_start_o    (do_start),
    .do_init_o     (do_init),
    .do_acc_o      (do_acc),
    .do_step_o     (do_step),
    .req_valid_o   (mem_req_valid_o),
    .done_o        (done_o),
    .pause_ev_o    (pause_ev),
    .resume_fire_o (resume_fire)
  );

  sumloop_datapath #(.DW(DW), .AW(AW), .IW(IW)) i_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_i     (paused_q),
    .do_start_i (do_start),
    .do_init_i  (do_init),
    .do_acc_i   (do_acc),
    .do_step_i  (do_step),
    .ld_i       (resume_fire),
    .cfg_wr_i   (cfg_wr_i && host_idle),
    .cfg_sel_i  (cfg_sel_i),
    .cfg_data_i (cfg_data_i),
    .base_i     (base_i),
    .count_i    (count_i),
    .rsp_data_i (mem_rsp_data_i),
    .sh_idx_i   (sh_idx),
    .sh_acc_i   (sh_acc),
    .sh_n_i     (sh_n),
    .sh_base_i  (sh_base),
    .sh_inc_i   (sh_inc),
    .sh_sub_i   (sh_sub),
    .idx_q      (idx_q),
    .acc_q      (acc_q),
    .idx_d      (idx_d),
    .acc_d      (acc_d),
    .n_d        (n_d),
    .base_d     (base_d),
    .inc_d      (inc_d),
    .sub_d      (sub_d),
    .mask_q     (mask_q),
    .lt_o       (lt),
    .addr_o     (mem_req_addr_o)
  );

  sumloop_scan #(.LEN(LEN)) i_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_i     (cap),
    .cap_vec_i (cap_vec),
    .shift_i   (shift),
    .sin_i     (scan_in_i),
    .chain_q   (chain_q),
    .sout_o    (scan_out_o)
  );

  // R3: a stalled request keeps valid and address steady
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o))
    else $error("p_req_hold_r3");

  // R1: completion is a single-cycle pulse
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o)
    else $error("p_done_pulse_r1");
endmodule

// File: tb/test_sumloop_accel.sv
`timescale 1ns/100ps
module test_sumloop_accel;
  localparam int L = 116;
  localparam int NV = 6;
  localparam logic [31:0] V_BASE [NV] = '{32'h0000_1000, 32'h0000_2000, 32'h0000_3000,
                                          32'h0000_0040, 32'hFFFF_FFF0, 32'h0000_0800};
  localparam logic [15:0] V_N    [NV] = '{16'd5, 16'd8, 16'd4, 16'd7, 16'd1, 16'd12};
  localparam logic [15:0] V_INC  [NV] = '{16'd1, 16'd2, 16'd1, 16'd3, 16'd1, 16'd5};
  localparam logic        V_SUB  [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
  localparam logic [31:0] V_INIT [NV] = '{32'd0, 32'h10, 32'd1000, 32'hFFFF_0000, 32'd5, 32'd0};
  localparam logic [7:0]  V_MASK [NV] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'hC0, 8'h00};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [15:0] count_i = '0;
  logic        done_o;
  logic [31:0] result_o;
  logic        cfg_wr_i = 1'b0;
  logic [1:0]  cfg_sel_i = '0;
  logic [31:0] cfg_data_i = '0;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b0;
  logic [31:0] mem_req_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [31:0] mem_rsp_data_i = '0;
  logic        exc_o;
  logic        scan_en_i = 1'b0;
  logic        scan_in_i = 1'b0;
  logic        scan_out_o;
  logic        resume_i = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  int rd_cnt = 0;
  logic [31:0] rd_addr [64];

  always #2.5 clk = ~clk;

  sumloop_accel i_sumloop_accel (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i), .count_i(count_i),
    .done_o(done_o), .result_o(result_o), .cfg_wr_i(cfg_wr_i), .cfg_sel_i(cfg_sel_i),
    .cfg_data_i(cfg_data_i), .mem_req_valid_o(mem_req_valid_o),
    .mem_req_ready_i(mem_req_ready_i), .mem_req_addr_o(mem_req_addr_o),
    .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_data_i(mem_rsp_data_i), .exc_o(exc_o),
    .scan_en_i(scan_en_i), .scan_in_i(scan_in_i), .scan_out_o(scan_out_o),
    .resume_i(resume_i)
  );

  function automatic logic [31:0] memf(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h1234_5678;
  endfunction

  function automatic logic [31:0] expect_sum(input logic [31:0] base, input logic [15:0] n,
                                             input logic [15:0] inc, input logic sub,
                                             input logic [31:0] init);
    logic [31:0] acc = init;
    for (int k = 0; k < int'(n); k += int'(inc)) begin
      logic [31:0] w = memf(base + 32'(k) * 4);
      acc = sub ? acc - w : acc + w;
    end
    return acc;
  endfunction

  function automatic logic [L-1:0] pack(input logic [2:0] st, input logic [15:0] idx,
                                        input logic [31:0] acc, input logic [15:0] n,
                                        input logic [31:0] base, input logic [15:0] inc,
                                        input logic sub);
    return {st, idx, acc, n, base, inc, sub};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: random ready, random response latency, one read at a time
  initial begin
    bit busy = 0;
    bit hs = 0;
    int lat = 0;
    logic [31:0] maddr = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid_i = 1'b0;
      if (hs) begin
        busy = 1; hs = 0; lat = int'($urandom % 4);
      end
      if (busy) begin
        if (lat == 0) begin
          mem_rsp_valid_i = 1'b1; mem_rsp_data_i = memf(maddr); busy = 0;
        end else lat--;
      end
      mem_req_ready_i = 1'b0;
      if (!busy && mem_req_valid_o && ($urandom % 3 != 0)) begin
        mem_req_ready_i = 1'b1; hs = 1; maddr = mem_req_addr_o;
        if (rd_cnt < 64) rd_addr[rd_cnt] = mem_req_addr_o;
        rd_cnt++;
      end
    end
  end

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_wr_i = 1'b1; cfg_sel_i = sel; cfg_data_i = data;
    @(negedge clk);
    cfg_wr_i = 1'b0;
  endtask

  task automatic pulse_start(input logic [31:0] base, input logic [15:0] n);
    @(negedge clk);
    start_i = 1'b1; base_i = base; count_i = n;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output logic [31:0] res, output bit seen);
    seen = 0; res = '0;
    for (int c = 0; c < 3000 && !seen; c++) begin
      if (done_o) begin seen = 1; res = result_o; end
      else @(negedge clk);
    end
  endtask

  task automatic wait_exc(output bit seen);
    seen = 0;
    for (int c = 0; c < 3000 && !seen; c++) begin
      if (exc_o) seen = 1;
      else @(negedge clk);
    end
  endtask

  task automatic scan_xfer(input logic [L-1:0] vin, output logic [L-1:0] vout);
    vout = '0;
    for (int i = 0; i < L; i++) begin
      vout = {vout[L-2:0], scan_out_o};
      scan_in_i = vin[L-1-i];
      scan_en_i = 1'b1;
      @(negedge clk);
    end
    scan_en_i = 1'b0;
  endtask

  task automatic do_resume();
    resume_i = 1'b1;
    @(negedge clk);
    resume_i = 1'b0;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] res, expv;
    logic [L-1:0] vo, vi;
    logic [31:0] m0, m1, m2, acc_e;
    bit seen;
    int dn;

    repeat (3) @(negedge clk);
    // R12: reset state
    chk(done_o == 0, "R12 done after reset", done_o, 0);
    chk(mem_req_valid_o == 0, "R12 req after reset", mem_req_valid_o, 0);
    chk(exc_o == 0, "R12 exc after reset", exc_o, 0);
    chk(scan_out_o == 0, "R12 scan_out after reset", scan_out_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table: R1, R3, R4, R5, R6, R7 (ignored mask bits)
    for (int v = 0; v < NV; v++) begin
      cfg_write(2'd0, 32'(V_INC[v]));
      cfg_write(2'd1, V_INIT[v]);
      cfg_write(2'd2, 32'(V_SUB[v]));
      cfg_write(2'd3, 32'(V_MASK[v]));
      rd_cnt = 0;
      pulse_start(V_BASE[v], V_N[v]);
      wait_done(res, seen);
      expv = expect_sum(V_BASE[v], V_N[v], V_INC[v], V_SUB[v], V_INIT[v]);
      chk(seen && res == expv, "R1 R4 R5 R6 result", res, expv);
      @(negedge clk);
      chk(done_o == 0, "R1 done single cycle", done_o, 0);
      chk(rd_cnt == (int'(V_N[v]) + int'(V_INC[v]) - 1) / int'(V_INC[v]),
          "R3 R4 read count", rd_cnt, 0);
      begin
        bit ok = 1;
        for (int k = 0; k < rd_cnt && k < 64; k++)
          if (rd_addr[k] != V_BASE[v] + {16'(k * int'(V_INC[v])), 2'b00}) ok = 0;
        chk(ok, "R3 read addresses", rd_cnt, 0);
      end
      chk(exc_o == 0, "R7 ignored mask bits give no stop", exc_o, 0);
    end

    // R2: zero count
    cfg_write(2'd0, 32'd1);
    cfg_write(2'd2, 32'd0);
    cfg_write(2'd3, 32'd0);
    cfg_write(2'd1, 32'h0000_ABCD);
    rd_cnt = 0;
    pulse_start(32'h0000_9000, 16'd0);
    wait_done(res, seen);
    chk(seen && res == 32'h0000_ABCD, "R2 zero count result", res, 32'h0000_ABCD);
    chk(rd_cnt == 0, "R2 zero count no reads", rd_cnt, 0);

    // R11: start and config writes while busy are ignored
    cfg_write(2'd1, 32'd0);
    rd_cnt = 0;
    pulse_start(32'h0000_5000, 16'd6);
    @(negedge clk);
    start_i = 1'b1; base_i = 32'h0000_6000; count_i = 16'd2;
    @(negedge clk);
    start_i = 1'b0;
    cfg_write(2'd1, 32'd77);
    wait_done(res, seen);
    expv = expect_sum(32'h0000_5000, 16'd6, 16'd1, 1'b0, 32'd0);
    chk(seen && res == expv, "R11 start while busy ignored", res, expv);
    dn = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (done_o) dn++;
    end
    chk(dn == 0 && rd_cnt == 6, "R11 no second job", rd_cnt, 6);
    pulse_start(32'h0000_9000, 16'd0);
    wait_done(res, seen);
    chk(res == 32'd0, "R11 init write while busy ignored", res, 0);

    // R7 R10: stop on entry to the entry block, resume unchanged
    cfg_write(2'd3, 32'h02);
    rd_cnt = 0;
    pulse_start(32'h0000_7800, 16'd2);
    wait_exc(seen);
    chk(seen, "R7 stop on entry block", exc_o, 1);
    dn = 0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (done_o || mem_req_valid_o || !exc_o) dn++;
    end
    chk(dn == 0 && rd_cnt == 0, "R7 stopped engine idle", rd_cnt, 0);
    scan_xfer('0, vo);
    chk(vo[L-1 -: 3] == 3'd1, "R8 captured block code", vo[L-1 -: 3], 1);
    scan_xfer(vo, vi);
    do_resume();
    wait_done(res, seen);
    expv = expect_sum(32'h0000_7800, 16'd2, 16'd1, 1'b0, 32'd0);
    chk(seen && res == expv, "R10 resume at patched block", res, expv);

    // R7 R8 R10: stop on each step, software edits state
    cfg_write(2'd1, 32'h11);
    cfg_write(2'd3, 32'h10);
    rd_cnt = 0;
    m0 = memf(32'h0000_7000); m1 = memf(32'h0000_7004); m2 = memf(32'h0000_7008);
    pulse_start(32'h0000_7000, 16'd3);
    wait_exc(seen);
    acc_e = 32'h11 + m0;
    vi = pack(3'd2, 16'd1, acc_e + 32'h100, 16'd3, 32'h0000_7000, 16'd1, 1'b0);
    scan_xfer(vi, vo);
    chk(vo == pack(3'd4, 16'd0, acc_e, 16'd3, 32'h0000_7000, 16'd1, 1'b0),
        "R8 first stop vector", vo, pack(3'd4, 16'd0, acc_e, 16'd3, 32'h0000_7000, 16'd1, 1'b0));
    chk(rd_cnt == 1 && !done_o, "R7 stop after first body", rd_cnt, 1);
    do_resume();
    chk(exc_o == 0, "R10 exc cleared by resume", exc_o, 0);
    wait_exc(seen);
    acc_e = acc_e + 32'h100 + m1;
    vi = pack(3'd4, 16'd1, acc_e, 16'd3, 32'h0000_7000, 16'd1, 1'b0);
    scan_xfer(vi, vo);
    chk(seen && vo == vi, "R8 R10 second stop vector", vo, vi);
    do_resume();
    wait_exc(seen);
    acc_e = acc_e + m2;
    vi = pack(3'd4, 16'd2, acc_e, 16'd3, 32'h0000_7000, 16'd1, 1'b0);
    scan_xfer(vi, vo);
    chk(seen && vo == vi, "R10 no recheck on resumed block", vo, vi);
    do_resume();
    wait_done(res, seen);
    chk(seen && res == acc_e, "R10 patched job result", res, acc_e);
    @(negedge clk);
    scan_xfer('0, vo);
    vi = pack(3'd0, 16'd3, acc_e, 16'd3, 32'h0000_7000, 16'd1, 1'b0);
    chk(vo == vi, "R8 completion capture", vo, vi);

    // R9: shifting while idle leaves the next job untouched
    cfg_write(2'd3, 32'h00);
    cfg_write(2'd1, 32'd0);
    scan_xfer(pack(3'd1, 16'd5, 32'hDEAD, 16'd9, 32'h9999, 16'd2, 1'b1), vo);
    dn = 0;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      if (done_o || mem_req_valid_o || exc_o) dn++;
    end
    chk(dn == 0, "R9 idle shift starts nothing", dn, 0);
    rd_cnt = 0;
    pulse_start(32'h0000_0100, 16'd3);
    wait_done(res, seen);
    expv = expect_sum(32'h0000_0100, 16'd3, 16'd1, 1'b0, 32'd0);
    chk(seen && res == expv && rd_cnt == 3, "R9 job after idle shift", res, expv);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule